// File: doc/BRIEF.md
# Cumulative Warning Sign Lamp Sequencer

This block drives the lamp groups of a blinking roadside warning sign. While the enable switch is held on, the lit area grows one group per clock cycle. First every lamp is dark. Then the first group comes on, then the second is added, then the last. After the last group the sign goes dark again and the build-up starts over. When the switch is turned off, the sign returns to dark on the next clock edge and stays dark.

The sequencer is a Moore machine. A step counter holds the present position in the sequence. The lamp outputs are flops loaded with the thermometer decode of the next step, so each lamp pin always shows the decode of the present step, with no combinational path from the switch to a pin. With the default of three groups:

- bit 0 drives lamps 1 and 2.
- bit 1 drives lamps 3 and 4.
- bit 2 drives lamp 5.

Reducing the step to a visible blink rate belongs upstream, as a clock enable or a slow clock.

Top module: `warn_sign_ctrl`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, `lamp_grp` is all zeros after that edge.
- R2: With `switch_on` high at the first rising edge after reset, `lamp_grp` becomes 3'b001 after that edge.
- R3: With `switch_on` high at each edge, `lamp_grp` steps 000 → 001 → 011 → 111 → 000 and repeats. In general, a full vector goes to all zeros, and any other value shifts left by one with a 1 entering bit 0.
- R4: If `switch_on` is low at a rising edge, `lamp_grp` is all zeros after that edge, from every step.
- R5: `lamp_grp` is always a thermometer code: the lit bits are a contiguous run starting at bit 0.
- R6: `lamp_grp` changes only at a rising clock edge. Moving `switch_on` between edges has no effect on `lamp_grp` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one sequence step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| switch_on | input | 1 | Enable switch level; low collapses the sequence to dark |
| lamp_grp | output | GROUPS (3) | Lamp group drives; bit 0 = lamps 1–2, bit 1 = lamps 3–4, bit 2 = lamp 5 |

## Verification
The bound checker watches every cycle for the following:

- Reset clears the lamps.
- A low switch darkens the sign on the next edge.
- The lamp vector stays a thermometer code.
- Each enabled edge either grows the vector by one bit or wraps a full vector to dark.

Only the bench scenarios can show two further behaviours. The first is that a switch toggled between edges leaves the pins untouched. The second is that the full repeating sequence, including wrap-around after long random on/off runs, matches an independent step model.

// File: rtl/warn_sign_pkg.sv
package warn_sign_pkg;
  localparam int unsigned DEF_GROUPS = 3;

  function automatic logic [31:0] advance(logic [31:0] cur, logic en,
                                          logic [31:0] last_step);
    if (!en) return 32'd0;
    if (cur >= last_step) return 32'd0;
    return cur + 32'd1;
  endfunction
endpackage

// File: rtl/sign_step_ctr.sv
module sign_step_ctr #(
  parameter int unsigned GROUPS = warn_sign_pkg::DEF_GROUPS,
  localparam int unsigned STEP_W = $clog2(GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_d
);
  localparam logic [31:0] LAST = 32'(GROUPS);

  always_comb begin
    step_d = STEP_W'(warn_sign_pkg::advance(32'(step_q), en, LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/sign_lamp_decode.sv
module sign_lamp_decode #(
  parameter int unsigned GROUPS = warn_sign_pkg::DEF_GROUPS,
  localparam int unsigned STEP_W = $clog2(GROUPS + 1)
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [GROUPS-1:0] grp_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_thermo
    assign grp_o[g] = (step_i > STEP_W'(g));
  end
endmodule

// File: rtl/sign_lamp_reg.sv
module sign_lamp_reg #(
  parameter int unsigned GROUPS = warn_sign_pkg::DEF_GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GROUPS-1:0] d,
  output logic [GROUPS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/warn_sign_ctrl.sv
module warn_sign_ctrl #(
  parameter int unsigned GROUPS = warn_sign_pkg::DEF_GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              switch_on,
  output logic [GROUPS-1:0] lamp_grp
);
  localparam int unsigned STEP_W = $clog2(GROUPS + 1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic [GROUPS-1:0] grp_next;

  sign_step_ctr #(.GROUPS(GROUPS)) u_ctr (
    .clk(clk), .rst(rst), .en(switch_on), .step_q(step_q), .step_d(step_d)
  );

  sign_lamp_decode #(.GROUPS(GROUPS)) u_dec (
    .step_i(step_d), .grp_o(grp_next)
  );

  sign_lamp_reg #(.GROUPS(GROUPS)) u_out (
    .clk(clk), .rst(rst), .d(grp_next), .q(lamp_grp)
  );
endmodule

// File: rtl/warn_sign_chk.sv
module warn_sign_chk #(
  parameter int unsigned GROUPS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              switch_on,
  input logic [GROUPS-1:0] lamp_grp
);
  // R1
  reset_dark_chk: assert property (@(posedge clk) rst |=> lamp_grp == '0);

  // R4
  switch_off_dark_chk: assert property (@(posedge clk) disable iff (rst)
    !switch_on |=> lamp_grp == '0);

  // R5
  thermo_code_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_grp & GROUPS'(lamp_grp + 1'b1)) == '0);

  // R3
  wrap_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (switch_on && lamp_grp == '1) |=> lamp_grp == '0);

  // R3
  grow_step_chk: assert property (@(posedge clk) disable iff (rst)
    (switch_on && lamp_grp != '1) |=> lamp_grp == {$past(lamp_grp[GROUPS-2:0]), 1'b1});
endmodule

bind warn_sign_ctrl warn_sign_chk #(.GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst(rst), .switch_on(switch_on), .lamp_grp(lamp_grp)
);

// File: tb/warn_sign_ctrl_bench.sv
module warn_sign_ctrl_bench;
  localparam int G = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         switch_on = 1'b0;
  logic [G-1:0] lamp_grp;

  int checks = 0;
  int errors = 0;
  int exp_step = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  warn_sign_ctrl u_warn_sign_ctrl (
    .clk(clk), .rst(rst), .switch_on(switch_on), .lamp_grp(lamp_grp)
  );

  function automatic logic [G-1:0] thermo(int s);
    logic [G-1:0] v;
    for (int i = 0; i < G; i++) v[i] = (s > i);
    return v;
  endfunction

  function automatic int model_next(int s, bit r, bit sw);
    if (r || !sw) return 0;
    return (s >= G) ? 0 : s + 1;
  endfunction

  task automatic check(string req, logic [G-1:0] act, logic [G-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, optional mid-cycle switch toggle, sample after edge
  task automatic cyc(bit r, bit sw, bit toggle, string req);
    @(negedge clk);
    rst = r;
    switch_on = sw;
    if (toggle) begin
      #1 switch_on = ~sw;
      #1 check("R6 mid-cycle switch", lamp_grp, thermo(exp_step));
      #1 switch_on = sw;
    end
    @(posedge clk);
    exp_step = model_next(exp_step, r, sw);
    #1 check(req, lamp_grp, thermo(exp_step));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    cyc(1, 1, 0, "R1 reset");
    cyc(1, 1, 0, "R1 reset held");
    // R2 first step after reset
    cyc(0, 1, 0, "R2 first lit group");
    // R3 full sequence with wrap, twice
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, "R3 sequence");
    // R4 switch off from every step
    for (int s = 0; s <= G; s++) begin
      while (exp_step != s) cyc(0, 1, 0, "R3 approach");
      cyc(0, 0, 0, "R4 off collapses");
      cyc(0, 0, 0, "R4 stays dark");
    end
    // R6 mid-cycle toggles in both directions
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, "R3 with toggle");
    cyc(0, 0, 1, "R4 with toggle");
    // R1 reset in mid sequence
    cyc(0, 1, 0, "R3 pre-reset");
    cyc(0, 1, 0, "R3 pre-reset");
    cyc(1, 1, 0, "R1 mid-sequence reset");
    // R5 random on/off runs
    for (int i = 0; i < 400; i++) begin
      bit sw = ($urandom % 4) != 0;
      bit r = ($urandom % 64) == 0;
      cyc(r, sw, ($urandom % 8) == 0, "R5 random");
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule